// File: doc/BRIEF.md
# Lockable Display Timing Generator

This block produces the raster timing for a display: a horizontal pixel counter, a vertical line counter, a blank output, CRT horizontal and vertical sync, and a second pair of sync outputs for a flat panel. All timing comes from registers on a simple 32-bit word bus. Each timing register holds two 16-bit fields, and each field is the intended count minus one. A key register guards every register behind it. Writes to the timing and control registers are accepted only after software has written the unlock key. Writing any other value to the key register locks the file again.

Software typically unlocks the block and clears the run bit, which stops the counters and blanks the output. It then loads the span, blank and sync registers, sets the enable bits and writes a wrong key to relock. The panel vertical sync has its own register, so software can place it one line ahead of the CRT vertical sync.

Word addresses: 0 key, 1 control, 2 horizontal span, 3 horizontal blank, 4 horizontal sync, 5 vertical span, 6 vertical blank, 7 vertical sync, 8 panel horizontal sync, 9 panel vertical sync. Every span register holds active-minus-one in bits 15:0 and total-minus-one in bits 31:16. Every blank or sync register holds start-minus-one in bits 15:0 and end-minus-one in bits 31:16. The control bits are: bit 0 run, bit 1 blank enable, bit 2 CRT hsync enable, bit 3 CRT vsync enable, bit 4 panel enable (panel power and panel syncs).

Top module: `disp_timing_gen`

## Requirements
- R1: After reset the block is locked, every register reads 0, both counters are 0, blank_o is 1, and all sync outputs and pnl_pwr_o are 0.
- R2: A write to address 0 unlocks the block when the data equals the KEY parameter and locks it for any other value, including 0. Reading address 0 returns the lock state in bit 0 (1 = unlocked) and 0 in the other bits.
- R3: While the block is locked, writes to addresses 1 to 9 are dropped and leave the readback and the outputs unchanged. Reads are accepted at all times.
- R4: While the block is unlocked, a write to address 2 to 9 stores all 32 bits and reads back unchanged. The control register at address 1 reads back its 5 bits. Unmapped addresses read 0.
- R5: With run set, h_count_o advances by one each cycle. After the cycle in which it equals or exceeds the total field (bits 31:16 of address 2), it returns to 0. v_count_o advances only on that return and wraps in the same way against bits 31:16 of address 5.
- R6: With run set, blank_o is 1 when blank enable is set and either h_count_o lies in the window (start field, end field] of address 3, or v_count_o lies in that window of address 6. Otherwise blank_o is 0.
- R7: With run set, hsync_o is 1 when hsync enable is set and h_count_o lies in the window of address 4. vsync_o is 1 when vsync enable is set and v_count_o lies in the window of address 7. Both outputs are active high.
- R8: pnl_pwr_o follows control bit 4. With run and that bit both set, pnl_hsync_o and pnl_vsync_o are 1 when h_count_o lies in the window of address 8 and v_count_o lies in the window of address 9, respectively.
- R9: While run is clear, blank_o is 1 and all four sync outputs are 0. From the cycle after run is observed clear, both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| h_count_o | output | 16 | Horizontal pixel counter |
| v_count_o | output | 16 | Vertical line counter |
| blank_o | output | 1 | Blank, active high |
| hsync_o | output | 1 | CRT horizontal sync, active high |
| vsync_o | output | 1 | CRT vertical sync, active high |
| pnl_hsync_o | output | 1 | Panel horizontal sync |
| pnl_vsync_o | output | 1 | Panel vertical sync |
| pnl_pwr_o | output | 1 | Panel power enable |

## Verification
The bench goes after four kinds of error.

- **Lock escapes.** It writes the span and control registers while locked and with a wrong key. A design that leaked such a write would read back nonzero or start counting.
- **Off-by-one windows.** It programs random windows and also a zero-width total field. A design that compared against the field plus one, or used the wrong inclusive bound, would move blank and sync edges by one pixel or line, or fail to advance a line every cycle when the total field is 0.
- **Stopping run mid-frame.** It clears run partway through a frame. A design that froze the counters instead of zeroing them, or left syncs driven, would show stale counts.
- **Swapped panel registers.** It gives the panel sync registers windows that differ from the CRT ones. A design that shared a register between the two would produce coinciding edges.

// File: rtl/disp_timing_gen.sv
module disp_timing_gen #(
  parameter int          AW  = 4,
  parameter logic [31:0] KEY = 32'h0000_5A3C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic [15:0]   h_count_o,
  output logic [15:0]   v_count_o,
  output logic          blank_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          pnl_hsync_o,
  output logic          pnl_vsync_o,
  output logic          pnl_pwr_o
);
  localparam int NT   = 8;
  localparam int BASE = 2;
  localparam int CTLW = 5;

  localparam int I_HSPAN = 0, I_HBLANK = 1, I_HSYNC = 2;
  localparam int I_VSPAN = 3, I_VBLANK = 4, I_VSYNC = 5;
  localparam int I_PHSYNC = 6, I_PVSYNC = 7;

  localparam int C_RUN = 0, C_BLANK = 1, C_HS = 2, C_VS = 3, C_PNL = 4;

  logic            unlocked;
  logic [CTLW-1:0] ctrl;
  logic [31:0]     treg [NT];
  logic [15:0]     h_cnt, v_cnt;

  function automatic logic in_win(input logic [15:0] c, input logic [31:0] r);
    return (c > r[15:0]) && (c <= r[31:16]);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      ctrl     <= '0;
      for (int i = 0; i < NT; i++) treg[i] <= '0;
    end else if (wr_en) begin
      if (addr == AW'(0)) unlocked <= (wdata == KEY);
      if (unlocked) begin
        if (addr == AW'(1)) ctrl <= wdata[CTLW-1:0];
        for (int i = 0; i < NT; i++)
          if (addr == AW'(i + BASE)) treg[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(0)) rdata = {31'd0, unlocked};
    if (addr == AW'(1)) rdata = {{(32-CTLW){1'b0}}, ctrl};
    for (int i = 0; i < NT; i++)
      if (addr == AW'(i + BASE)) rdata = treg[i];
  end

  wire [15:0] h_tot = treg[I_HSPAN][31:16];
  wire [15:0] v_tot = treg[I_VSPAN][31:16];
  wire        run   = ctrl[C_RUN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (!run) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (h_cnt >= h_tot) begin
      h_cnt <= '0;
      v_cnt <= (v_cnt >= v_tot) ? 16'd0 : v_cnt + 16'd1;
    end else begin
      h_cnt <= h_cnt + 16'd1;
    end
  end

  wire h_bl = in_win(h_cnt, treg[I_HBLANK]);
  wire v_bl = in_win(v_cnt, treg[I_VBLANK]);

  assign h_count_o   = h_cnt;
  assign v_count_o   = v_cnt;
  assign blank_o     = !run || (ctrl[C_BLANK] && (h_bl || v_bl));
  assign hsync_o     = run && ctrl[C_HS] && in_win(h_cnt, treg[I_HSYNC]);
  assign vsync_o     = run && ctrl[C_VS] && in_win(v_cnt, treg[I_VSYNC]);
  assign pnl_hsync_o = run && ctrl[C_PNL] && in_win(h_cnt, treg[I_PHSYNC]);
  assign pnl_vsync_o = run && ctrl[C_PNL] && in_win(v_cnt, treg[I_PVSYNC]);
  assign pnl_pwr_o   = ctrl[C_PNL];
endmodule

// File: rtl/disp_timing_chk.sv
module disp_timing_chk #(
  parameter int          AW  = 4,
  parameter logic [31:0] KEY = 32'h0000_5A3C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic          unlocked,
  input logic [4:0]    ctrl,
  input logic [15:0]   h_tot,
  input logic [15:0]   h_count_o,
  input logic [15:0]   v_count_o,
  input logic          blank_o,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          pnl_hsync_o,
  input logic          pnl_vsync_o
);
  a_r2_key_decides_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(0)) |=> (unlocked == ($past(wdata) == KEY)));

  a_r3_locked_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked && addr != AW'(0)) |=> ($stable(ctrl) && $stable(h_tot)));

  a_r5_h_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && h_count_o < h_tot) |=> (h_count_o == $past(h_count_o) + 16'd1));

  a_r5_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && h_count_o >= h_tot) |=> (h_count_o == 16'd0));

  a_r5_v_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && h_count_o < h_tot) |=> $stable(v_count_o));

  a_r9_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> (blank_o && !hsync_o && !vsync_o && !pnl_hsync_o && !pnl_vsync_o));

  a_r9_idle_counts: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |=> (h_count_o == 16'd0 && v_count_o == 16'd0));
endmodule

bind disp_timing_gen disp_timing_chk #(.AW(AW), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .unlocked(unlocked), .ctrl(ctrl), .h_tot(h_tot),
  .h_count_o(h_count_o), .v_count_o(v_count_o), .blank_o(blank_o),
  .hsync_o(hsync_o), .vsync_o(vsync_o),
  .pnl_hsync_o(pnl_hsync_o), .pnl_vsync_o(pnl_vsync_o)
);

// File: tb/tb_disp_timing_gen.sv
`timescale 1ns/1ps
module tb_disp_timing_gen;
  localparam logic [31:0] KEY = 32'h0000_5A3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] h_count_o, v_count_o;
  logic        blank_o, hsync_o, vsync_o, pnl_hsync_o, pnl_vsync_o, pnl_pwr_o;

  always #10 clk = ~clk;

  disp_timing_gen #(.AW(4), .KEY(KEY)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .h_count_o(h_count_o), .v_count_o(v_count_o),
    .blank_o(blank_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .pnl_hsync_o(pnl_hsync_o), .pnl_vsync_o(pnl_vsync_o), .pnl_pwr_o(pnl_pwr_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit chk_on = 1'b0;

  logic [31:0] m_reg [16];
  logic        m_unl;
  logic [15:0] m_h, m_v;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic win(input logic [15:0] c, input logic [31:0] r);
    return (c > r[15:0]) && (c <= r[31:16]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_unl <= 1'b0; m_h <= '0; m_v <= '0;
      for (int i = 0; i < 16; i++) m_reg[i] <= '0;
    end else begin
      if (!m_reg[1][0]) begin
        m_h <= '0; m_v <= '0;
      end else if (m_h >= m_reg[2][31:16]) begin
        m_h <= '0;
        m_v <= (m_v >= m_reg[5][31:16]) ? 16'd0 : m_v + 16'd1;
      end else m_h <= m_h + 16'd1;
      if (wr_en) begin
        if (addr == 4'd0) m_unl <= (wdata == KEY);
        else if (m_unl && addr == 4'd1) m_reg[1] <= {27'd0, wdata[4:0]};
        else if (m_unl && addr >= 4'd2 && addr <= 4'd9) m_reg[addr] <= wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      logic [4:0] c;
      logic run;
      c = m_reg[1][4:0];
      run = c[0];
      chk(h_count_o == m_h && v_count_o == m_v, "R5 counters",
          {h_count_o, v_count_o}, {m_h, m_v});
      chk(blank_o == (!run || (c[1] && (win(m_h, m_reg[3]) || win(m_v, m_reg[6])))),
          run ? "R6 blank" : "R9 blank", 32'(blank_o), 32'(!blank_o));
      chk(hsync_o == (run && c[2] && win(m_h, m_reg[4])) &&
          vsync_o == (run && c[3] && win(m_v, m_reg[7])),
          run ? "R7 crt sync" : "R9 crt sync", {hsync_o, vsync_o},
          {(run && c[2] && win(m_h, m_reg[4])), (run && c[3] && win(m_v, m_reg[7]))});
      chk(pnl_hsync_o == (run && c[4] && win(m_h, m_reg[8])) &&
          pnl_vsync_o == (run && c[4] && win(m_v, m_reg[9])) && pnl_pwr_o == c[4],
          run ? "R8 panel" : "R9 panel", {pnl_hsync_o, pnl_vsync_o, pnl_pwr_o},
          {(run && c[4] && win(m_h, m_reg[8])), (run && c[4] && win(m_v, m_reg[9])), c[4]});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] rnd_win(input int tot);
    int s, e;
    s = $urandom_range(tot, 0);
    e = $urandom_range(tot, s);
    return {16'(e), 16'(s)};
  endfunction

  task automatic program_frame(input int ht, input int vt, input logic [4:0] en);
    wr(4'd0, KEY);
    wr(4'd1, 32'd0);
    wr(4'd2, {16'(ht), 16'(ht > 0 ? ht - 1 : 0)});
    wr(4'd3, rnd_win(ht));
    wr(4'd4, rnd_win(ht));
    wr(4'd5, {16'(vt), 16'(vt > 0 ? vt - 1 : 0)});
    wr(4'd6, rnd_win(vt));
    wr(4'd7, rnd_win(vt));
    wr(4'd8, rnd_win(ht));
    wr(4'd9, rnd_win(vt));
    wr(4'd1, {27'd0, en});
    wr(4'd0, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      chk(d == 32'd0, "R1 reset register", d, 32'd0);
    end
    chk(h_count_o == 0 && v_count_o == 0 && blank_o && !hsync_o && !vsync_o &&
        !pnl_hsync_o && !pnl_vsync_o && !pnl_pwr_o, "R1 reset outputs",
        {h_count_o, v_count_o}, 32'd0);

    wr(4'd2, 32'h0009_0003);
    wr(4'd1, 32'h1F);
    repeat (4) @(negedge clk);
    rd(4'd2, d); chk(d == 32'd0, "R3 locked span write", d, 32'd0);
    rd(4'd1, d); chk(d == 32'd0, "R3 locked ctrl write", d, 32'd0);
    chk(h_count_o == 0 && blank_o && !pnl_pwr_o, "R3 outputs unchanged", 32'(h_count_o), 32'd0);

    wr(4'd0, KEY ^ 32'h1);
    rd(4'd0, d); chk(d == 32'd0, "R2 wrong key stays locked", d, 32'd0);
    wr(4'd1, 32'h1);
    rd(4'd1, d); chk(d == 32'd0, "R3 write after wrong key", d, 32'd0);
    wr(4'd0, KEY);
    rd(4'd0, d); chk(d == 32'd1, "R2 key unlocks", d, 32'd1);

    for (int a = 2; a < 10; a++) begin
      logic [31:0] v;
      v = $urandom();
      wr(4'(a), v);
      rd(4'(a), d);
      chk(d == v, "R4 readback", d, v);
    end
    wr(4'd1, 32'hFFFF_FFE0);
    rd(4'd1, d); chk(d == 32'd0, "R4 ctrl upper bits", d, 32'd0);
    wr(4'd1, 32'h16);
    rd(4'd1, d); chk(d == 32'h16, "R4 ctrl readback", d, 32'h16);
    rd(4'd12, d); chk(d == 32'd0, "R4 unmapped read", d, 32'd0);
    wr(4'd1, 32'd0);

    wr(4'd0, 32'd0);
    rd(4'd0, d); chk(d == 32'd0, "R2 zero relocks", d, 32'd0);
    wr(4'd5, 32'h1234_5678);
    rd(4'd5, d); chk(d != 32'h1234_5678, "R3 relocked write dropped", d, 32'd0);

    chk_on = 1'b1;

    program_frame(0, 3, 5'h1F);
    repeat (12) @(negedge clk);

    for (int k = 0; k < 10; k++) begin
      int ht, vt;
      ht = $urandom_range(12, 1);
      vt = $urandom_range(6, 1);
      program_frame(ht, vt, {$urandom_range(15, 0), 1'b1} [4:0]);
      repeat ((ht + 1) * (vt + 1) * 2 + 3) @(negedge clk);
    end

    program_frame(7, 4, 5'h1F);
    repeat (13) @(negedge clk);
    wr(4'd0, KEY);
    wr(4'd1, 32'h1E);
    repeat (3) @(negedge clk);
    chk(h_count_o == 0 && v_count_o == 0 && blank_o && !hsync_o && !pnl_hsync_o,
        "R9 stop mid frame", {h_count_o, v_count_o}, 32'd0);
    wr(4'd1, 32'h1F);
    wr(4'd0, 32'd0);
    repeat (60) @(negedge clk);

    chk_on = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule